// File: doc/BRIEF.md
# Prefix-OR Unary Priority Encoder

This combinational block finds the first set bit of a request vector whose positions are numbered upward from bit 0. Bit 0 wins over every other bit. The block returns two vectors of the same width as its input.

The first output, the "seen" vector, sets bit i when any request from bit 0 up to and including bit i is set. It is a running OR. The second output is the bitwise inverse of the seen vector. This gives the position of the winning request as a unary count: ones fill every position below the winner, and zeros fill the winner's position and everything above it.

The running OR is built by splitting the vector in half and solving each half the same way. The right-half results are then patched with the last result of the left half. The width must be a power of two. A caller with another width pads the unused top positions with zeros. The block has no clock and no state.

Top module: `pfx_unary_enc`

## Requirements
- R1: For every i, seen_o[i] equals the OR of req_i[0] through req_i[i].
- R2: unary_o is the bitwise inverse of seen_o for every input.
- R3: For a nonzero input whose lowest set position is j, unary_o[i] is 1 for every i < j and 0 for every i >= j.
- R4: An all-zero input drives seen_o to all zeros and unary_o to all ones, which is the unary code for N.
- R5: When req_i[0] is 1, seen_o is all ones and unary_o is all zeros, whatever the higher bits hold.
- R6: seen_o is monotone in position: if seen_o[i] is 1, then seen_o[i+1] is 1.
- R7: With N = 1, seen_o[0] equals req_i[0] and unary_o[0] is its inverse.
- R8: With N = 8, the input that sets positions 1, 2 and 4 (value 8'h16) gives seen_o = 8'hFE and unary_o = 8'h01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | N | Request vector; bit 0 has the highest priority |
| seen_o | output | N | Running OR from bit 0 up to each position |
| unary_o | output | N | Unary code of the winning position (inverse of seen_o) |

## Verification
The bench targets the points where a recursive split tends to break.

- **Lost patch from the left half:** if a half-boundary drops the carry, a request in the left half stops setting the bits of the right half.
- **Wrong carry bit:** if the carry is taken from the wrong left-half output, a request just below the boundary is missed.
- **Reversed priority:** if the scan runs from the top index down, single-bit inputs at the two ends give mirrored codes.
- **Zero input:** a design that gets this wrong shows a stray zero in the all-ones unary code.

To catch these, every pattern is applied exhaustively at widths 1, 2, 4 and 8. At width 32, each single-bit input, each two-bit input around a boundary, and random inputs are applied.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   // True when v is a nonzero power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Number of halving levels for a power-of-two width.
   function automatic int unsigned levels(input int unsigned v);
      int unsigned n;
      n = 0;
      while ((32'd1 << n) < v) n++;
      return n;
   endfunction

endpackage

// File: rtl/pfx_merge.sv
// Patches the right-half running OR with the last left-half result.
module pfx_merge #(
   parameter int unsigned HALF = 1
) (
   input  logic            carry_i,
   input  logic [HALF-1:0] raw_i,
   output logic [HALF-1:0] fixed_o
);

   for (genvar k = 0; k < HALF; k++) begin : g_bit
      assign fixed_o[k] = raw_i[k] | carry_i;
   end

endmodule

// File: rtl/pfx_or_rec.sv
// Running OR by recursive halving; bit 0 is the lowest position.
module pfx_or_rec #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] x_i,
   output logic [N-1:0] y_o
);

   localparam int unsigned H = (N > 1) ? N / 2 : 1;

   if (N == 1) begin : g_leaf
      // R7: a single position passes straight through
      assign y_o = x_i;
   end else begin : g_split
      logic [H-1:0] left_y;
      logic [H-1:0] right_raw;
      logic [H-1:0] right_y;

      pfx_or_rec #(.N(H)) u_left (
         .x_i (x_i[H-1:0]),
         .y_o (left_y)
      );

      pfx_or_rec #(.N(H)) u_right (
         .x_i (x_i[N-1:H]),
         .y_o (right_raw)
      );

      pfx_merge #(.HALF(H)) u_fix (
         .carry_i (left_y[H-1]),
         .raw_i   (right_raw),
         .fixed_o (right_y)
      );

      assign y_o = {right_y, left_y};
   end

endmodule

// File: rtl/pfx_unary_enc.sv
// Top: running OR plus its inverse, the unary code of the first set bit.
module pfx_unary_enc #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] seen_o,
   output logic [N-1:0] unary_o
);

   localparam int unsigned DEPTH = pfx_pkg::levels(N);

   if (!pfx_pkg::is_pow2(N)) begin : g_bad_width
      $fatal(1, "pfx_unary_enc: N=%0d is not a power of two", N);
   end

   if (DEPTH > 16) begin : g_too_deep
      $fatal(1, "pfx_unary_enc: N=%0d exceeds supported depth", N);
   end

   logic [N-1:0] prefix;

   pfx_or_rec #(.N(N)) u_tree (
      .x_i (req_i),
      .y_o (prefix)
   );

   assign seen_o  = prefix;
   assign unary_o = ~prefix;

endmodule

// File: rtl/pfx_unary_enc_chk.sv
module pfx_unary_enc_chk #(
   parameter int unsigned N = 8
) (
   input logic [N-1:0] req_i,
   input logic [N-1:0] seen_o,
   input logic [N-1:0] unary_o
);

   always_comb begin
      a_r2_inverse : assert (unary_o == ~seen_o)
         else $error("R2 unary_o not inverse of seen_o");
      a_r1_first : assert (seen_o[0] == req_i[0])
         else $error("R1 seen_o[0] mismatch");
      a_r1_last : assert (seen_o[N-1] == (|req_i))
         else $error("R1 seen_o[N-1] mismatch");
      a_r4_zero : assert ((|req_i) || (&unary_o))
         else $error("R4 zero input must give all-ones unary");
      a_r5_top : assert (!req_i[0] || (&seen_o))
         else $error("R5 bit 0 must saturate seen_o");
   end

   for (genvar k = 0; k < N; k++) begin : g_pos
      always_comb begin
         // R3: no set request may lie inside the run of ones
         a_r3_run_clear : assert (!(unary_o[k] && req_i[k]))
            else $error("R3 request inside unary run at %0d", k);
         a_r1_hit : assert (!req_i[k] || seen_o[k])
            else $error("R1 set request not seen at %0d", k);
      end
   end

   for (genvar k = 0; k + 1 < N; k++) begin : g_step
      always_comb begin
         a_r6_monotone : assert (!seen_o[k] || seen_o[k+1])
            else $error("R6 seen_o drops after %0d", k);
      end
   end

endmodule

bind pfx_unary_enc pfx_unary_enc_chk #(.N(N)) u_chk (
   .req_i   (req_i),
   .seen_o  (seen_o),
   .unary_o (unary_o)
);

// File: tb/pfx_unary_enc_test.sv
module pfx_unary_enc_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [0:0]  v1 = '0;
   logic [1:0]  v2 = '0;
   logic [3:0]  v4 = '0;
   logic [7:0]  v8 = '0;
   logic [31:0] v32 = '0;
   logic [0:0]  s1, u1;
   logic [1:0]  s2, u2;
   logic [3:0]  s4, u4;
   logic [7:0]  s8, u8;
   logic [31:0] s32, u32;

   pfx_unary_enc #(.N(1))  uut_w1  (.req_i(v1),  .seen_o(s1),  .unary_o(u1));
   pfx_unary_enc #(.N(2))  uut_w2  (.req_i(v2),  .seen_o(s2),  .unary_o(u2));
   pfx_unary_enc #(.N(4))  uut_w4  (.req_i(v4),  .seen_o(s4),  .unary_o(u4));
   pfx_unary_enc #(.N(8))  uut     (.req_i(v8),  .seen_o(s8),  .unary_o(u8));
   pfx_unary_enc #(.N(32)) uut_w32 (.req_i(v32), .seen_o(s32), .unary_o(u32));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Behavioural model: scan from position 0 upward.
   function automatic logic [63:0] ref_seen(input int w, input logic [63:0] v);
      logic [63:0] r;
      logic acc;
      r = '0;
      acc = 1'b0;
      for (int k = 0; k < w; k++) begin
         acc = acc | v[k];
         r[k] = acc;
      end
      return r;
   endfunction

   function automatic int lead_pos(input int w, input logic [63:0] v);
      for (int k = 0; k < w; k++) if (v[k]) return k;
      return w;
   endfunction

   function automatic logic [63:0] mask(input int w);
      return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
   endfunction

   task automatic expect_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_width(input int w, input logic [63:0] v,
                              input logic [63:0] s, input logic [63:0] u);
      logic [63:0] es, eu;
      int j;
      es = ref_seen(w, v);
      j  = lead_pos(w, v);
      eu = mask(w) & ((64'd1 << j) - 64'd1);
      expect_eq("R1", $sformatf("seen w=%0d in=%h", w, v), s, es);
      expect_eq("R2", $sformatf("inverse w=%0d in=%h", w, v), u, mask(w) & ~s);
      if (v == 0) begin
         expect_eq("R4", $sformatf("zero seen w=%0d", w), s, 64'd0);
         expect_eq("R4", $sformatf("zero unary w=%0d", w), u, mask(w));
      end else begin
         expect_eq("R3", $sformatf("unary w=%0d in=%h", w, v), u, eu);
      end
      if (v[0]) expect_eq("R5", $sformatf("bit0 w=%0d in=%h", w, v), s, mask(w));
      for (int k = 0; k + 1 < w; k++)
         if (s[k]) expect_eq("R6", $sformatf("monotone w=%0d pos=%0d", w, k),
                             {63'd0, s[k+1]}, 64'd1);
   endtask

   task automatic check_all();
      check_width(1,  {63'd0, v1},  {63'd0, s1},  {63'd0, u1});
      check_width(2,  {62'd0, v2},  {62'd0, s2},  {62'd0, u2});
      check_width(4,  {60'd0, v4},  {60'd0, s4},  {60'd0, u4});
      check_width(8,  {56'd0, v8},  {56'd0, s8},  {56'd0, u8});
      check_width(32, {32'd0, v32}, {32'd0, s32}, {32'd0, u32});
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // initial all-zero state
      expect_eq("R4", "initial unary w=8", {56'd0, u8}, 64'hFF);
      expect_eq("R4", "initial seen w=32", {32'd0, s32}, 64'd0);

      // R7: single-bit width
      for (int b = 0; b < 2; b++) begin
         @(posedge clk); v1 = b[0];
         @(negedge clk);
         expect_eq("R7", "w1 seen", {63'd0, s1}, {63'd0, b[0]});
         expect_eq("R7", "w1 unary", {63'd0, u1}, {63'd0, ~b[0]});
      end

      // exhaustive at widths 2, 4 and 8
      for (int c = 0; c < 256; c++) begin
         @(posedge clk);
         v1 = c[0]; v2 = c[1:0]; v4 = c[3:0]; v8 = c[7:0];
         v32 = {c[7:0], c[7:0], ~c[7:0], c[7:0]};
         @(negedge clk);
         check_all();
      end

      // R8: worked example, positions 1, 2 and 4 set
      @(posedge clk); v8 = 8'h16;
      @(negedge clk);
      expect_eq("R8", "example seen", {56'd0, s8}, 64'hFE);
      expect_eq("R8", "example unary", {56'd0, u8}, 64'h01);

      // single bits and boundary pairs at width 32
      for (int p = 0; p < 32; p++) begin
         @(posedge clk); v32 = 32'd1 << p;
         @(negedge clk); check_all();
         @(posedge clk); v32 = (32'd1 << p) | 32'h8000_0000;
         @(negedge clk); check_all();
      end
      for (int p = 1; p < 32; p++) begin
         @(posedge clk); v32 = 32'd3 << (p - 1);
         @(negedge clk); check_all();
      end

      // random patterns at width 32
      for (int n = 0; n < 400; n++) begin
         @(posedge clk);
         v32 = $urandom() & ($urandom() | $urandom());
         @(negedge clk);
         check_all();
      end

      @(posedge clk); v32 = '0;
      @(negedge clk);
      check_all();

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule